// File: doc/BRIEF.md
# Dual Codec Power State Sequencer

This block moves a pair of audio codecs, a primary and a secondary, between four device power levels, D0 (fully on) to D3 (deepest). A host asks for a level with a single-cycle request. The block then turns that level into a cumulative power-down control word and writes the same word to both codecs' power registers over a simple write-only register bus (address, data, valid, ready).

The order of the two writes depends on the direction of the change. When the new level uses less power, the secondary codec is written first. When the new level uses more power (resume), the primary codec is written first. A mobile-mode input, sampled when a request is accepted, permits the link-shutdown and internal-clock-stop bits. Without mobile mode those two bits are never driven. A busy flag, a one-cycle done pulse and the current level register let the host follow the progress.

Top module: `codec_pwr_sequencer`

## Requirements
- R1: After reset, cur_state is 0 (D0) and busy, done and bus_valid are all low.
- R2: The 16-bit word written for each level without mobile mode is fixed. D0 writes 0x0000. D1 writes 0x0003 (ADC and DAC off, bits 0 and 1). D2 writes 0x0087 (adds mixer bit 2 and external amplifier bit 7). D3 writes 0x008F (adds reference bit 3). Bit 6 and bits 15:8 are always 0.
- R3: A request accepted with mobile_en high for level D3 writes 0x00BF, which adds link-down bit 4 and clock-stop bit 5. The value of mobile_en after acceptance has no effect. Bits 4 and 5 are never set unless mobile_en was high at acceptance.
- R4: A level change makes exactly two bus writes with the same data. One goes to primary address 0x26 and the other to secondary address 0xA6.
- R5: When the requested level number is greater than cur_state (less power), the first write goes to 0xA6 and the second to 0x26.
- R6: When the requested level number is smaller than cur_state (resume), the first write goes to 0x26 and the second to 0xA6.
- R7: A request equal to cur_state makes no bus write. busy stays low, and done pulses in the cycle after acceptance.
- R8: While bus_valid is high and bus_ready is low, bus_valid, bus_addr and bus_data hold at the next cycle.
- R9: busy is high from the cycle after a level-changing request is accepted until the handshake of the second write. A request raised while busy is ignored.
- R10: done is high for the single cycle after the second write's handshake. cur_state takes the new level in that same cycle and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Level request strobe, accepted when not busy |
| req_state | input | 2 | Requested level, 0 = D0 to 3 = D3 |
| mobile_en | input | 1 | Permits link-down and clock-stop bits, sampled at acceptance |
| bus_addr | output | 8 | Codec register address |
| bus_data | output | 16 | Power-down word |
| bus_valid | output | 1 | Write request |
| bus_ready | input | 1 | Write accepted when high together with bus_valid |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_state | output | 2 | Level last completed |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a stalled write pair. The host must raise req_valid while the bus is holding one write, and the bench must then show that the ignored request changed neither the write order, the write count nor the final level. The stimulus injects a second request one cycle into some sequences. It does this under three ready patterns: always ready, randomly stalled, and stalled for several cycles at the start. The levels and mobile_en are drawn at random, so downward, upward and repeated requests occur in mixed order. Directed cases cover the D3 mobile word and a change of mobile_en right after acceptance.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pstate_t;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_t;

  localparam int PD_ADC  = 0;
  localparam int PD_DAC  = 1;
  localparam int PD_MIX  = 2;
  localparam int PD_REF  = 3;
  localparam int PD_LINK = 4;
  localparam int PD_CLK  = 5;
  localparam int PD_AMP  = 7;

  // Cumulative power-down byte for a level; link and clock bits only in mobile D3
  function automatic logic [7:0] pd_bits(input pstate_t lvl, input logic mobile);
    logic [7:0] w;
    w = 8'h00;
    if (lvl != PS_D0) begin
      w[PD_ADC] = 1'b1;
      w[PD_DAC] = 1'b1;
    end
    if (lvl == PS_D2 || lvl == PS_D3) begin
      w[PD_MIX] = 1'b1;
      w[PD_AMP] = 1'b1;
    end
    if (lvl == PS_D3) begin
      w[PD_REF]  = 1'b1;
      w[PD_LINK] = mobile;
      w[PD_CLK]  = mobile;
    end
    return w;
  endfunction

endpackage

// File: rtl/codec_pwr_encode.sv
module codec_pwr_encode
  import codec_pwr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  pstate_t           level,
  input  logic              mobile,
  output logic [DATA_W-1:0] word
);
  localparam int PAD_W = DATA_W - 8;

  logic [7:0] low_byte;
  assign low_byte = pd_bits(level, mobile);

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, low_byte};
    end else begin : g_nopad
      assign word = low_byte[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/codec_pwr_order.sv
module codec_pwr_order #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 8'h26,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 8'hA6
) (
  input  logic              going_down,
  input  logic              second_slot,
  output logic [ADDR_W-1:0] addr
);
  // Down: secondary then primary. Up: primary then secondary.
  logic pick_primary;
  assign pick_primary = (going_down == second_slot);
  assign addr = pick_primary ? PRI_ADDR : SEC_ADDR;
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  pstate_t req_lvl,
  input  logic    mobile_en,
  input  logic    bus_ready,
  output seq_t    seq_st,
  output pstate_t target_q,
  output pstate_t cur_q,
  output logic    mob_q,
  output logic    down_q,
  output logic    done_q,
  output logic    accept,
  output logic    accept_same,
  output logic    final_hs
);
  assign accept      = req_valid && (seq_st == SEQ_IDLE);
  assign accept_same = accept && (req_lvl == cur_q);
  assign final_hs    = (seq_st == SEQ_SECOND) && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_st   <= SEQ_IDLE;
      target_q <= PS_D0;
      cur_q    <= PS_D0;
      mob_q    <= 1'b0;
      down_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (seq_st)
        SEQ_IDLE: begin
          if (accept) begin
            target_q <= req_lvl;
            mob_q    <= mobile_en;
            down_q   <= (req_lvl > cur_q);
            if (accept_same) done_q <= 1'b1;
            else             seq_st <= SEQ_FIRST;
          end
        end
        SEQ_FIRST: begin
          if (bus_ready) seq_st <= SEQ_SECOND;
        end
        SEQ_SECOND: begin
          if (final_hs) begin
            seq_st <= SEQ_IDLE;
            done_q <= 1'b1;
            cur_q  <= target_q;
          end
        end
        default: seq_st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/codec_pwr_sequencer.sv
module codec_pwr_sequencer
  import codec_pwr_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 8'h26,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_state,
  input  logic              mobile_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cur_state
);
  seq_t    seq_st;
  pstate_t target_q;
  pstate_t cur_q;
  logic    mob_q;
  logic    down_q;
  logic    done_q;
  logic    accept;
  logic    accept_same;
  logic    final_hs;
  logic    in_second;

  codec_pwr_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_lvl     (pstate_t'(req_state)),
    .mobile_en   (mobile_en),
    .bus_ready   (bus_ready),
    .seq_st      (seq_st),
    .target_q    (target_q),
    .cur_q       (cur_q),
    .mob_q       (mob_q),
    .down_q      (down_q),
    .done_q      (done_q),
    .accept      (accept),
    .accept_same (accept_same),
    .final_hs    (final_hs)
  );

  codec_pwr_encode #(.DATA_W(DATA_W)) enc_i (
    .level  (target_q),
    .mobile (mob_q),
    .word   (bus_data)
  );

  assign in_second = (seq_st == SEQ_SECOND);

  codec_pwr_order #(
    .ADDR_W   (ADDR_W),
    .PRI_ADDR (PRI_ADDR),
    .SEC_ADDR (SEC_ADDR)
  ) ord_i (
    .going_down  (down_q),
    .second_slot (in_second),
    .addr        (bus_addr)
  );

  assign bus_valid = (seq_st != SEQ_IDLE);
  assign busy      = bus_valid;
  assign done      = done_q;
  assign cur_state = cur_q;
endmodule

// File: rtl/codec_pwr_sequencer_chk.sv
module codec_pwr_sequencer_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 8'h26,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 8'hA6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              busy,
  input logic              done,
  input logic [1:0]        cur_state,
  input logic              mob_q,
  input logic              down_q,
  input logic              accept,
  input logic              accept_same
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data)); // R8

  AST_DOWN_SEC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) && down_q |-> bus_addr == SEC_ADDR); // R5

  AST_UP_PRI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) && !down_q |-> bus_addr == PRI_ADDR); // R6

  AST_LINK_BITS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !mob_q |-> bus_data[5:4] == 2'b00); // R3

  AST_SAME_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_same |=> !bus_valid && !busy && done); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !accept_same |=> busy); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_valid); // R10

  AST_STATE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_state) |-> done); // R10
endmodule

bind codec_pwr_sequencer codec_pwr_sequencer_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PRI_ADDR (PRI_ADDR),
  .SEC_ADDR (SEC_ADDR)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_data    (bus_data),
  .bus_valid   (bus_valid),
  .bus_ready   (bus_ready),
  .busy        (busy),
  .done        (done),
  .cur_state   (cur_state),
  .mob_q       (mob_q),
  .down_q      (down_q),
  .accept      (accept),
  .accept_same (accept_same)
);

// File: tb/codec_pwr_sequencer_tb_top.sv
module codec_pwr_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_state = 2'd0;
  logic        mobile_en = 1'b0;
  logic [7:0]  bus_addr;
  logic [15:0] bus_data;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic        busy;
  logic        done;
  logic [1:0]  cur_state;

  int n_checks = 0;
  int n_fails  = 0;
  int model_cur = 0;
  int edges = 0;

  always #10 clk = ~clk;

  codec_pwr_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .mobile_en(mobile_en), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .busy(busy), .done(done),
    .cur_state(cur_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected word restated from the level list, not from the design's encoder
  function automatic int exp_word(input int lvl, input bit mob);
    case (lvl)
      0: return 'h0000;
      1: return 'h0003;
      2: return 'h0087;
      default: return mob ? 'h00BF : 'h008F;
    endcase
  endfunction

  always @(posedge clk) begin
    edges++;
    if (edges > 150000) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", edges, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  task automatic run_req(input int t, input bit mob, input int rmode, input bit inject);
    int  ew, nwr, cyc, a0, a1;
    bit  same, down, stall, rdy;
    logic [7:0]  pa;
    logic [15:0] pd;
    string rq;
    same = (t == model_cur);
    down = (t > model_cur);
    ew = exp_word(t, mob);
    rq = (t == 3 && mob) ? "R3" : "R2";
    nwr = 0; cyc = 0; a0 = -1; a1 = -1; stall = 0; pa = '0; pd = '0;
    req_valid = 1'b1; req_state = 2'(t); mobile_en = mob;
    @(negedge clk);
    req_valid = 1'b0;
    mobile_en = ~mob;  // R3: later value must not matter
    if (same) begin
      chk(done && !busy && !bus_valid, "R7", {done, busy, bus_valid}, 3'b100);
      chk(cur_state == 2'(t), "R7", cur_state, t);
      @(negedge clk);
      chk(!done && !bus_valid, "R7", {done, bus_valid}, 0);
      return;
    end
    while (!done && cyc < 400) begin
      req_valid = 1'b0;
      chk(busy && bus_valid, "R9", {busy, bus_valid}, 3);
      if (stall) chk(bus_addr == pa && bus_data == pd, "R8", bus_data, pd);
      case (rmode)
        0: rdy = 1'b1;
        1: rdy = ($urandom % 3) != 0;
        default: rdy = (cyc >= 5) && (($urandom % 2) != 0);
      endcase
      if (inject && cyc == 1) begin
        req_valid = 1'b1;
        req_state = 2'((t + 1) % 4);
      end
      if (bus_valid && rdy) begin
        chk(bus_data == 16'(ew), rq, bus_data, ew);
        if (nwr == 0) a0 = bus_addr; else a1 = bus_addr;
        nwr++;
      end
      stall = bus_valid && !rdy;
      pa = bus_addr; pd = bus_data;
      bus_ready = rdy;
      @(negedge clk);
      cyc++;
    end
    bus_ready = 1'b0;
    req_valid = 1'b0;
    chk(done && !busy && !bus_valid, "R10", {done, busy, bus_valid}, 3'b100);
    chk(cur_state == 2'(t), "R10", cur_state, t);
    chk(nwr == 2, "R4", nwr, 2);
    if (down) begin
      chk(a0 == 'hA6 && a1 == 'h26, "R5", {a0[7:0], a1[7:0]}, 'hA626);
    end else begin
      chk(a0 == 'h26 && a1 == 'hA6, "R6", {a0[7:0], a1[7:0]}, 'h26A6);
    end
    @(negedge clk);
    chk(!done && !busy && cur_state == 2'(t), "R10", {done, busy, cur_state}, t);
    model_cur = t;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(cur_state == 2'd0 && !busy && !done && !bus_valid, "R1",
        {cur_state, busy, done, bus_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_state == 2'd0 && !busy && !done && !bus_valid, "R1",
        {cur_state, busy, done, bus_valid}, 0);
    run_req(1, 0, 0, 0);   // down, no stall
    run_req(3, 0, 1, 0);   // down, desktop D3
    run_req(0, 0, 2, 0);   // resume with long stall
    run_req(3, 1, 1, 0);   // mobile D3
    run_req(3, 1, 0, 0);   // same level
    run_req(2, 0, 0, 1);   // up with request while busy (R9)
    run_req(0, 1, 2, 1);   // mobile has no effect below D3
    for (int i = 0; i < 80; i++) begin
      run_req($urandom % 4, 1'($urandom % 2), $urandom % 3, ($urandom % 4) == 0);
    end
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule